// File: doc/BRIEF.md
# Banked GPIO Controller with Masked-Write Aliases

This block is a memory-mapped general-purpose I/O controller that handles several banks of eight pins each. Every pin is owned either by the GPIO registers or by a special-function source elsewhere on the chip. A per-pin ownership bit selects the owner. When the GPIO registers own a pin, the pin's output level and output-enable come from the bank's data and direction registers. Otherwise they are passed through from the special-function inputs.

Software can write a whole byte of ownership, direction or level at once. It can also change chosen pins without reading the register first. It does this through masked aliases: in the write word, bits [15:8] say which pins to touch and bits [7:0] give their new values. Pad inputs pass through a two-flop synchronizer and can be read back per bank. The register port is a plain 32-bit bus. A write is applied on a clock edge, and a read returns data combinationally from the address.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset, the ownership, direction and level registers of every bank read as zero. Every pad_out and pad_oe bit then equals the matching sf_out and sf_oe bit.
- R2: For pin i of bank b (flat index b*8+i), an ownership bit of 1 drives pad_out from the level register and pad_oe from the direction register. An ownership bit of 0 drives them from sf_out and sf_oe.
- R3: A write to a plain register (ownership +0x00, direction +0x10, level +0x20) replaces bits [7:0] with wr_data[7:0]. wr_data[31:8] has no effect. Reads return the register in bits [7:0] and zero in bits [31:8].
- R4: A write to the masked direction alias (+0x90) sets direction bit i to wr_data[i] only where wr_data[i+8] is 1. Every other bit keeps its value. A direction value of 1 means drive and 0 means tristate.
- R5: A write to the masked level alias (+0xA0) follows the same rule for the level register. The level register reads back the last value written, whatever the pin's direction or ownership.
- R6: A write to the masked ownership alias (+0x80) follows the same rule for the ownership register, so a single pin can be claimed while the others stay unchanged.
- R7: The input register (+0x30) returns the pad_in levels of the bank in bits [7:0]. A pad change is not visible after one rising edge and becomes visible after the second.
- R8: Bank b has its base at (b/4)*0x100 + (b%4)*4. The register offsets above are added to that base.
- R9: Misaligned addresses, banks at or above NUM_BANKS, unused offsets and the masked aliases all read as zero. Writes to those addresses, and writes to the input register, change no register.
- R10: A write takes effect on the rising edge that samples wr_en. Before that edge, a read of the same address still returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for reg_addr |
| pad_in | input | NUM_BANKS*8 | Asynchronous pad levels |
| sf_out | input | NUM_BANKS*8 | Special-function output levels |
| sf_oe | input | NUM_BANKS*8 | Special-function output enables |
| pad_out | output | NUM_BANKS*8 | Level driven to each pad |
| pad_oe | output | NUM_BANKS*8 | Output enable for each pad |

## Verification
The bench builds the block with NUM_BANKS=6 and ADDR_W=12. Banks 4 and 5 therefore sit in the second 0x100 group, at 0x100 and 0x104. This exercises the group arithmetic of the bank base, not just the four-bank offset stride. Slots 6 and 7 of that group stay unmapped, so random writes to them test that out-of-range banks are ignored. Random masks mix with directed single-pin claims, and ownership is toggled while the pads are compared with a bench model.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int PINS_PER_BANK = 8;
  localparam int BANKS_PER_GROUP = 4;

  // register kind codes, taken from address bits [7:4]
  localparam logic [3:0] KIND_OWN   = 4'h0;
  localparam logic [3:0] KIND_DIR   = 4'h1;
  localparam logic [3:0] KIND_LVL   = 4'h2;
  localparam logic [3:0] KIND_PIN   = 4'h3;
  localparam logic [3:0] KIND_M_OWN = 4'h8;
  localparam logic [3:0] KIND_M_DIR = 4'h9;
  localparam logic [3:0] KIND_M_LVL = 4'hA;

  // masked update: upper byte enables, lower byte supplies values
  function automatic logic [7:0] masked_merge(input logic [7:0] old_v,
                                              input logic [15:0] wd);
    return (old_v & ~wd[15:8]) | (wd[7:0] & wd[15:8]);
  endfunction

  function automatic logic kind_writable(input logic [3:0] k);
    return (k == KIND_OWN) || (k == KIND_DIR) || (k == KIND_LVL) ||
           (k == KIND_M_OWN) || (k == KIND_M_DIR) || (k == KIND_M_LVL);
  endfunction

  function automatic logic kind_readable(input logic [3:0] k);
    return (k == KIND_OWN) || (k == KIND_DIR) || (k == KIND_LVL) || (k == KIND_PIN);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  // cycles since reset, saturating, used only by the check below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assign dout = stage2_q;

  // R7: output equals the input sampled two edges earlier
  a_r7_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
module gpio_pin_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] own_gpio,
  input  logic [W-1:0] gp_lvl,
  input  logic [W-1:0] gp_dir,
  input  logic [W-1:0] sf_lvl,
  input  logic [W-1:0] sf_dir,
  output logic [W-1:0] mux_lvl,
  output logic [W-1:0] mux_dir
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    assign mux_lvl[p] = own_gpio[p] ? gp_lvl[p] : sf_lvl[p];
    assign mux_dir[p] = own_gpio[p] ? gp_dir[p] : sf_dir[p];
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [3:0]  wr_kind,
  input  logic [15:0] wr_word,
  output logic [7:0]  own_q,
  output logic [7:0]  dir_q,
  output logic [7:0]  lvl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
      dir_q <= '0;
      lvl_q <= '0;
    end else if (wr_stb) begin
      case (wr_kind)
        KIND_OWN:   own_q <= wr_word[7:0];
        KIND_DIR:   dir_q <= wr_word[7:0];
        KIND_LVL:   lvl_q <= wr_word[7:0];
        KIND_M_OWN: own_q <= masked_merge(own_q, wr_word);
        KIND_M_DIR: dir_q <= masked_merge(dir_q, wr_word);
        KIND_M_LVL: lvl_q <= masked_merge(lvl_q, wr_word);
        default: ;
      endcase
    end
  end

  // R10: without a strobe nothing moves
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(own_q) && $stable(dir_q) && $stable(lvl_q)));
  // R4: masked direction write leaves unselected bits alone
  a_r4_dir_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_kind == KIND_M_DIR) |=>
      (((dir_q ^ $past(dir_q)) & ~$past(wr_word[15:8])) == 8'h00));
  // R5: masked level write leaves unselected bits alone
  a_r5_lvl_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_kind == KIND_M_LVL) |=>
      (((lvl_q ^ $past(lvl_q)) & ~$past(wr_word[15:8])) == 8'h00));
  // R6: masked ownership write leaves unselected bits alone
  a_r6_own_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_kind == KIND_M_OWN) |=>
      (((own_q ^ $past(own_q)) & ~$past(wr_word[15:8])) == 8'h00));
endmodule

// File: rtl/banked_gpio_ctrl.sv
`timescale 1ns/1ps
module banked_gpio_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   wr_en,
  input  logic [31:0]            wr_data,
  output logic [31:0]            rd_data,
  input  logic [NUM_BANKS*8-1:0] pad_in,
  input  logic [NUM_BANKS*8-1:0] sf_out,
  input  logic [NUM_BANKS*8-1:0] sf_oe,
  output logic [NUM_BANKS*8-1:0] pad_out,
  output logic [NUM_BANKS*8-1:0] pad_oe
);
  localparam int NPINS = NUM_BANKS * PINS_PER_BANK;
  localparam int IDX_W = ADDR_W - 6;   // group bits plus two slot bits

  // address decode: [ADDR_W-1:8] group, [7:4] kind, [3:2] slot, [1:0] zero
  logic [IDX_W-1:0] bank_idx;
  logic [3:0]       kind;
  logic             aligned;
  logic             bank_ok;
  logic             wr_hit;
  logic             rd_hit;
  logic             unused_hi;

  assign bank_idx  = {reg_addr[ADDR_W-1:8], reg_addr[3:2]};
  assign kind      = reg_addr[7:4];
  assign aligned   = (reg_addr[1:0] == 2'b00);
  assign bank_ok   = (bank_idx < IDX_W'(NUM_BANKS));
  assign wr_hit    = wr_en && aligned && bank_ok && kind_writable(kind);
  assign rd_hit    = aligned && bank_ok && kind_readable(kind);
  assign unused_hi = ^wr_data[31:16];

  logic [NPINS-1:0] own_v, dir_v, lvl_v, sync_v;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic stb;
    assign stb = wr_hit && (bank_idx == IDX_W'(b));
    gpio_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (stb),
      .wr_kind (kind),
      .wr_word (wr_data[15:0]),
      .own_q   (own_v[b*8 +: 8]),
      .dir_q   (dir_v[b*8 +: 8]),
      .lvl_q   (lvl_v[b*8 +: 8])
    );
  end

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (sync_v)
  );

  gpio_pin_mux #(.W(NPINS)) u_mux (
    .own_gpio (own_v),
    .gp_lvl   (lvl_v),
    .gp_dir   (dir_v),
    .sf_lvl   (sf_out),
    .sf_dir   (sf_oe),
    .mux_lvl  (pad_out),
    .mux_dir  (pad_oe)
  );

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_hit && bank_idx == IDX_W'(b)) begin
        case (kind)
          KIND_OWN: rd_data[7:0] = own_v[b*8 +: 8];
          KIND_DIR: rd_data[7:0] = dir_v[b*8 +: 8];
          KIND_LVL: rd_data[7:0] = lvl_v[b*8 +: 8];
          KIND_PIN: rd_data[7:0] = sync_v[b*8 +: 8];
          default: ;
        endcase
      end
    end
  end

  // R9: unmapped reads are zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data == 32'h0));
  // R3: upper read bits never carry data
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:8] == 24'h0);
endmodule

// File: tb/banked_gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module banked_gpio_ctrl_tb_top;
  localparam int NB = 6;
  localparam int AW = 12;
  localparam int NP = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pad_in = '0, sf_out = '0, sf_oe = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit [7:0] m_own [NB];
  bit [7:0] m_dir [NB];
  bit [7:0] m_lvl [NB];

  always #5 clk = ~clk;

  banked_gpio_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .sf_out(sf_out), .sf_oe(sf_oe), .pad_out(pad_out), .pad_oe(pad_oe));

  function automatic logic [AW-1:0] addr_of(int bank, int off);
    return AW'((bank / 4) * 256 + (bank % 4) * 4 + off);
  endfunction

  // bench form of the masked update: bit by bit
  function automatic bit [7:0] apply_mask(bit [7:0] old_v, bit [31:0] d);
    bit [7:0] r = old_v;
    for (int i = 0; i < 8; i++) if (d[i+8]) r[i] = d[i];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic model_write(int bank, int off, bit [31:0] d);
    if (bank >= NB) return;
    case (off)
      'h00: m_own[bank] = d[7:0];
      'h10: m_dir[bank] = d[7:0];
      'h20: m_lvl[bank] = d[7:0];
      'h80: m_own[bank] = apply_mask(m_own[bank], d);
      'h90: m_dir[bank] = apply_mask(m_dir[bank], d);
      'hA0: m_lvl[bank] = apply_mask(m_lvl[bank], d);
      default: ;
    endcase
  endtask

  task automatic check_all_regs(string tag);
    logic [31:0] r;
    for (int b = 0; b < NB; b++) begin
      do_read(addr_of(b, 'h00), r); chk({tag, " own"}, 64'(r), 64'(m_own[b]));
      do_read(addr_of(b, 'h10), r); chk({tag, " dir"}, 64'(r), 64'(m_dir[b]));
      do_read(addr_of(b, 'h20), r); chk({tag, " lvl"}, 64'(r), 64'(m_lvl[b]));
    end
  endtask

  task automatic check_pads(string tag);
    logic [NP-1:0] eo, ee;
    for (int p = 0; p < NP; p++) begin
      eo[p] = m_own[p/8][p%8] ? m_lvl[p/8][p%8] : sf_out[p];
      ee[p] = m_own[p/8][p%8] ? m_dir[p/8][p%8] : sf_oe[p];
    end
    #1;
    chk({tag, " pad_out"}, 64'(pad_out), 64'(eo));
    chk({tag, " pad_oe"}, 64'(pad_oe), 64'(ee));
  endtask

  initial begin
    #(1_500_000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int offs [9] = '{'h00, 'h10, 'h20, 'h30, 'h80, 'h90, 'hA0, 'h40, 'hB0};
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin m_own[b] = 0; m_dir[b] = 0; m_lvl[b] = 0; end
    sf_out = {$urandom, $urandom}; sf_oe = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all_regs("R1 reset");
    check_pads("R1 reset");

    // R3 plain write, upper bits ignored; R8 second group bank
    do_write(addr_of(5, 'h20), 32'hFFFF_FF5A); model_write(5, 'h20, 32'hFFFF_FF5A);
    do_read(addr_of(5, 'h20), r); chk("R3 R8 lvl bank5 @0x124", 64'(r), 64'h5A);
    do_read(AW'('h124), r);        chk("R8 literal address 0x124", 64'(r), 64'h5A);

    // R6 claim a single pin
    do_write(addr_of(4, 'h80), 32'h0000_0808); model_write(4, 'h80, 32'h0808);
    do_write(addr_of(4, 'h80), 32'h0000_0101); model_write(4, 'h80, 32'h0101);
    do_read(AW'('h100), r); chk("R6 single claim bank4", 64'(r), 64'h09);

    // R5 level reads back with direction input and pin owned by special function
    do_write(addr_of(1, 'hA0), 32'h0000_F0A5); model_write(1, 'hA0, 32'hF0A5);
    do_read(addr_of(1, 'h20), r); chk("R5 readback while tristate", 64'(r), 64'hA0);

    // R4 masked direction
    do_write(addr_of(1, 'h90), 32'h0000_0F0F); model_write(1, 'h90, 32'h0F0F);
    do_write(addr_of(1, 'h90), 32'h0000_0300); model_write(1, 'h90, 32'h0300);
    do_read(addr_of(1, 'h10), r); chk("R4 masked dir", 64'(r), 64'h0C);

    // R2 take ownership of bank 1 and compare pads
    do_write(addr_of(1, 'h00), 32'h0000_00FF); model_write(1, 'h00, 32'hFF);
    check_pads("R2 bank1 owned");

    // R10 old value visible before the edge, new value after
    @(negedge clk);
    reg_addr = addr_of(2, 'h20); wr_data = 32'h0000_0033; wr_en = 1'b1;
    #1; chk("R10 before edge", 64'(rd_data), 64'(m_lvl[2]));
    @(negedge clk); wr_en = 1'b0; model_write(2, 'h20, 32'h33);
    do_read(addr_of(2, 'h20), r); chk("R10 after edge", 64'(r), 64'h33);

    // R9 unmapped: bank 6, misaligned, unused offset, alias read, IN write
    do_write(addr_of(6, 'h00), 32'h0000_00FF);
    do_write(addr_of(0, 'h01), 32'h0000_00FF);
    do_write(addr_of(0, 'h30), 32'h0000_00FF);
    do_write(addr_of(0, 'h40), 32'h0000_00FF);
    check_all_regs("R9 ignored writes");
    do_read(addr_of(6, 'h00), r); chk("R9 read bank6", 64'(r), 64'h0);
    do_read(addr_of(1, 'h90), r); chk("R9 alias read", 64'(r), 64'h0);
    do_read(addr_of(1, 'h22), r); chk("R9 misaligned read", 64'(r), 64'h0);

    // R7 synchronizer latency
    @(negedge clk); pad_in = {NP{1'b1}} ^ pad_in;
    @(negedge clk); do_read(addr_of(3, 'h30), r); chk("R7 after one edge", 64'(r), 64'h00);
    @(negedge clk); do_read(addr_of(3, 'h30), r); chk("R7 after two edges", 64'(r), 64'hFF);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int bank = $urandom_range(0, 7);
      int off = offs[$urandom_range(0, 8)];
      bit [31:0] d = $urandom;
      logic [AW-1:0] a = addr_of(bank, off);
      if ($urandom_range(0, 15) == 0) begin
        a = a + AW'($urandom_range(1, 3));
        off = -1;
      end
      sf_out = {$urandom, $urandom}; sf_oe = {$urandom, $urandom};
      @(negedge clk);
      pad_in = {$urandom, $urandom};
      do_write(a, d);
      if (off >= 0) model_write(bank, off, d);
      @(negedge clk);
      check_all_regs("R3 R4 R5 R6 R9 random");
      check_pads("R2 random");
      for (int b = 0; b < NB; b++) begin
        do_read(addr_of(b, 'h30), r);
        chk("R7 random input", 64'(r), 64'(pad_in[b*8 +: 8]));
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule